// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

A 16-bit timer-counter that sits on a simple byte-wide register bus. When it is clocked by the machine-cycle tick, it acts as an interval timer. When it is clocked by falling edges on an external count pin, it acts as an event counter. A trigger pin has three possible uses: it can latch a snapshot of the count, it can force a reload, or it can select the count direction.

Control bits choose one of three operating modes:
- **Capture:** the count wraps freely and trigger edges take snapshots.
- **Auto-reload:** the count is reloaded from the reload registers. An optional up/down variant treats the point where the count equals the reload value as its lower bound.
- **Baud generator:** each wrap emits a one-cycle tick for a serial port and reloads the count.

The block raises two sticky flags and an interrupt request. Software clears the flags by writing them.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every register reads 0x00 and ovf_flag_o, ext_flag_o, irq_o and baud_tick_o are 0.
- R2: Register map by address. 0 is control, 1 is mode, 2 and 3 are the reload/capture low and high bytes, and 4 and 5 are the count low and high bytes. Writes take effect at the clock edge and reads are combinational. Control bits: 7 overflow flag, 6 external flag, 5 receive-clock enable, 4 transmit-clock enable, 3 external enable, 2 run, 1 count-pin select, 0 capture select. Mode bit 0 enables up/down counting. Mode bit 1 is storage only. Mode bits 7..2 read 0.
- R3: With run=1 and count-pin select=0, the count advances by one at each clock edge where tick_i is high, and holds otherwise.
- R4: With count-pin select=1, cnt_pin_i is sampled at each tick. The count advances at a tick whose sample is 0 when the previous tick's sample was 1.
- R5: With run=0 the count holds, whatever the tick and the pins do.
- R6: Capture mode (capture select=1, both clock enables 0). A step past 0xFFFF gives 0x0000 and sets the overflow flag. With external enable=1, a trigger falling edge (sampled at ticks as in R4) copies the pre-step count into the reload/capture registers and sets the external flag.
- R7: Auto-reload mode with mode bit 0=0. A step past 0xFFFF loads the reload value and sets the overflow flag. With external enable=1, a trigger falling edge forces a reload and sets the external flag. With external enable=0, trigger edges have no effect.
- R8: Up/down mode (auto-reload with mode bit 0=1). trig_pin_i=1 counts up and trig_pin_i=0 counts down. An up wrap loads the reload value. A down step at a count equal to the reload value loads 0xFFFF. Both set the overflow flag and toggle the external flag.
- R9: irq_o is the overflow flag ORed with the external flag. The external flag is left out of irq_o while mode bit 0=1, capture select=0 and both clock enables are 0.
- R10: With either clock enable set, the block runs as a baud generator and capture select is ignored. A wrap loads the reload value and leaves the overflow flag untouched. baud_tick_o is high for exactly the one cycle after the wrapping edge.
- R11: The flags stay set until software writes 0 to them. A hardware set in the same cycle as a control write wins.
- R12: A write to a count byte takes priority over a step in the same cycle. The written byte takes the new value and the other byte keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Machine-cycle tick |
| cnt_pin_i | input | 1 | External count pin |
| trig_pin_i | input | 1 | Trigger / direction pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External flag |
| irq_o | output | 1 | Interrupt request |
| baud_tick_o | output | 1 | Baud overflow pulse |

## Verification
The count is checked step by step in four ways: across a run of plain ticks, across an irregular bit pattern on the count pin, and across down and up sequences in up/down mode. The pin pattern separates true falling-edge detection from level counting. The down sequence separates a compare against the reload value from a wrap at zero. Wrap behaviour is tried with several reload values, including 0x0000 and 0xFFFF, to tell a reload apart from a plain wrap. Same-cycle collisions are also tested: a register write against a step, and a control write against a flag set. These show which side wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF,
    MODE_CAPTURE,
    MODE_RELOAD,
    MODE_BAUD
  } tmr_mode_e;

  localparam int CB_OVF    = 7;
  localparam int CB_EXT    = 6;
  localparam int CB_RXCLK  = 5;
  localparam int CB_TXCLK  = 4;
  localparam int CB_EXTEN  = 3;
  localparam int CB_RUN    = 2;
  localparam int CB_CNTSEL = 1;
  localparam int CB_CAPSEL = 0;

  localparam int MB_UPDN = 0;
  localparam int MODE_W  = 2;

  function automatic tmr_mode_e decode_mode(input logic [7:0] ctrl);
    if (!ctrl[CB_RUN])                        return MODE_OFF;
    else if (ctrl[CB_RXCLK] || ctrl[CB_TXCLK]) return MODE_BAUD;
    else if (ctrl[CB_CAPSEL])                 return MODE_CAPTURE;
    else                                      return MODE_RELOAD;
  endfunction
endpackage

// File: rtl/tmr_edge_sampler.sv
module tmr_edge_sampler #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] smp_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     smp_q[i] <= 1'b0;
      else if (tick_i) smp_q[i] <= pin_i[i];
    end
    // a high sample followed by a low one at the next tick
    assign fall_o[i] = tick_i & smp_q[i] & ~pin_i[i];
  end
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter  int CNT_W = 16,
  localparam int NB    = CNT_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             down_i,
  input  logic             reload_on_wrap_i,
  input  logic             force_reload_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [NB-1:0]    wr_en_i,
  input  logic [7:0]       wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (step_i) begin
      if (down_i) begin
        if (cnt_q == reload_i) begin
          cnt_d  = '1;
          wrap_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else if (cnt_q == '1) begin
        cnt_d  = reload_on_wrap_i ? reload_i : '0;
        wrap_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (force_reload_i) cnt_d = reload_i;
    for (int b = 0; b < NB; b++) begin
      if (wr_en_i[b]) cnt_d[b*8 +: 8] = wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import tmr_pkg::*;
#(
  parameter  int CNT_W  = 16,
  localparam int NB     = CNT_W / 8,
  localparam int ADDR_W = $clog2(2 + 2 * NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              trig_pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              ovf_flag_o,
  output logic              ext_flag_o,
  output logic              irq_o,
  output logic              baud_tick_o
);
  localparam int A_CTRL = 0;
  localparam int A_MODE = 1;
  localparam int A_RLD  = 2;
  localparam int A_CNT  = 2 + NB;

  logic [7:0]        ctrl_q, ctrl_d;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  count;
  logic [NB-1:0]     cnt_wr, rld_wr;
  logic              ctrl_we, mode_we;
  logic [1:0]        fall;
  logic              cnt_fall, trig_fall;
  tmr_mode_e         mode;
  logic              run, baud_cfg, baud_on, ud_cfg;
  logic              step, wrap, trig_ev, force_reload, capture;
  logic              baud_q;

  assign ctrl_we = reg_we_i && (reg_addr_i == ADDR_W'(A_CTRL));
  assign mode_we = reg_we_i && (reg_addr_i == ADDR_W'(A_MODE));

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign rld_wr[b] = reg_we_i && (reg_addr_i == ADDR_W'(A_RLD + b));
    assign cnt_wr[b] = reg_we_i && (reg_addr_i == ADDR_W'(A_CNT + b));
  end

  tmr_edge_sampler #(.N(2)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .pin_i  ({trig_pin_i, cnt_pin_i}),
    .fall_o (fall)
  );
  assign cnt_fall  = fall[0];
  assign trig_fall = fall[1];

  assign mode     = decode_mode(ctrl_q);
  assign run      = ctrl_q[CB_RUN];
  assign baud_cfg = ctrl_q[CB_RXCLK] | ctrl_q[CB_TXCLK];
  assign baud_on  = (mode == MODE_BAUD);
  assign ud_cfg   = mode_q[MB_UPDN] & ~ctrl_q[CB_CAPSEL] & ~baud_cfg;

  assign step = run & (ctrl_q[CB_CNTSEL] ? cnt_fall : tick_i) & ~|cnt_wr;

  // trigger pin is a direction input in up/down mode, not an event
  assign trig_ev = trig_fall & ctrl_q[CB_EXTEN] & (mode != MODE_OFF) & ~(ud_cfg & (mode == MODE_RELOAD));
  assign force_reload = trig_ev & (mode == MODE_RELOAD);
  assign capture      = trig_ev & (mode == MODE_CAPTURE);

  tmr_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .step_i           (step),
    .down_i           (ud_cfg & ~trig_pin_i),
    .reload_on_wrap_i (mode != MODE_CAPTURE),
    .force_reload_i   (force_reload),
    .reload_i         (reload_q),
    .wr_en_i          (cnt_wr),
    .wr_data_i        (reg_wdata_i),
    .count_o          (count),
    .wrap_o           (wrap)
  );

  for (genvar b = 0; b < NB; b++) begin : g_rld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        reload_q[b*8 +: 8] <= 8'h00;
      else if (rld_wr[b]) reload_q[b*8 +: 8] <= reg_wdata_i;
      else if (capture)   reload_q[b*8 +: 8] <= count[b*8 +: 8];
    end
  end

  always_comb begin
    ctrl_d = ctrl_we ? reg_wdata_i : ctrl_q;
    if (wrap && !baud_on)  ctrl_d[CB_OVF] = 1'b1;
    if (trig_ev)           ctrl_d[CB_EXT] = 1'b1;
    if (wrap && ud_cfg)    ctrl_d[CB_EXT] = ~ctrl_d[CB_EXT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 8'h00;
      mode_q <= '0;
      baud_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (mode_we) mode_q <= reg_wdata_i[MODE_W-1:0];
      baud_q <= wrap & baud_on;
    end
  end

  always_comb begin
    reg_rdata_o = 8'h00;
    if (reg_addr_i == ADDR_W'(A_CTRL)) reg_rdata_o = ctrl_q;
    if (reg_addr_i == ADDR_W'(A_MODE)) reg_rdata_o = {{(8-MODE_W){1'b0}}, mode_q};
    for (int b = 0; b < NB; b++) begin
      if (reg_addr_i == ADDR_W'(A_RLD + b)) reg_rdata_o = reload_q[b*8 +: 8];
      if (reg_addr_i == ADDR_W'(A_CNT + b)) reg_rdata_o = count[b*8 +: 8];
    end
  end

  assign ovf_flag_o  = ctrl_q[CB_OVF];
  assign ext_flag_o  = ctrl_q[CB_EXT];
  assign irq_o       = ctrl_q[CB_OVF] | (ctrl_q[CB_EXT] & ~ud_cfg);
  assign baud_tick_o = baud_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             run_i,
  input logic             baud_i,
  input logic             ud_i,
  input logic             ctrl_we_i,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] count_i,
  input logic             ovf_i,
  input logic             ext_i,
  input logic             irq_i,
  input logic             baud_tick_i
);
  AST_TICK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr_i) |=> $stable(count_i)); // R3
  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i) |=> $stable(count_i)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !ctrl_we_i) |=> ovf_i); // R11
  AST_EXT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_i && !ctrl_we_i && !ud_i) |=> ext_i); // R11
  AST_BAUD_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (baud_i && run_i && !ctrl_we_i && !ovf_i) |=> !ovf_i); // R10
  AST_BAUD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_i |-> $past(baud_i && run_i && tick_i)); // R10
  AST_UD_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ud_i && !ovf_i) |-> !irq_i); // R9
  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (ovf_i || ext_i)); // R9
endmodule

bind cap_reload_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .run_i       (run),
  .baud_i      (baud_cfg),
  .ud_i        (ud_cfg),
  .ctrl_we_i   (ctrl_we),
  .cnt_wr_i    (|cnt_wr),
  .count_i     (count),
  .ovf_i       (ovf_flag_o),
  .ext_i       (ext_flag_o),
  .irq_i       (irq_o),
  .baud_tick_i (baud_tick_o)
);

// File: tb/cap_reload_timer_test.sv
`timescale 1ns/1ps
module cap_reload_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cnt_pin = 1'b0, trig_pin = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ovf, ext, irq, baud;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  cap_reload_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnt_pin_i(cnt_pin),
    .trig_pin_i(trig_pin), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ovf_flag_o(ovf),
    .ext_flag_o(ext), .irq_o(irq), .baud_tick_o(baud)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wr_tick(input int a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = 3'(a); wdata = d; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); addr = 3'(a); #1 d = rdata;
  endtask

  task automatic rd16(input int a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 1, hi); d = {hi, lo};
  endtask

  task automatic wr16(input int a, input logic [15:0] d);
    wr(a, d[7:0]); wr(a + 1, d[15:8]);
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] c, m, r;
    logic        prev, ovf_m, ext_m;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin rd(a, b); chk("R1 reg", b, 8'h00); end
    chk("R1 outs", {ovf, ext, irq, baud}, 4'b0000);

    // R2 register access
    wr16(2, 16'hA5C3); rd16(2, c); chk("R2 reload", c, 16'hA5C3);
    wr(1, 8'hFF); rd(1, b); chk("R2 mode", b, 8'h03);
    wr(1, 8'h00);
    wr16(4, 16'h00F0); rd16(4, c); chk("R2 count", c, 16'h00F0);

    // R3 timer function sweep
    wr(0, 8'h04);
    for (int n = 1; n <= 20; n++) begin
      step(1); rd16(4, c); chk("R3 step", c, 16'h00F0 + 16'(n));
    end
    repeat (5) @(negedge clk);
    rd16(4, c); chk("R3 no tick hold", c, 16'h0104);

    // R5 off holds
    wr(0, 8'h00); step(7); rd16(4, c); chk("R5 off", c, 16'h0104);

    // R4 counter function with irregular pin pattern
    wr16(4, 16'h0000); wr(0, 8'h06);
    prev = 1'b0; m = 16'h0000; lfsr = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cnt_pin = lfsr[0];
      step(1);
      if (prev && !cnt_pin) m++;
      prev = cnt_pin;
    end
    rd16(4, c); chk("R4 edge count", c, m);
    cnt_pin = 1'b0; wr(0, 8'h00); step(1);

    // R6 capture mode
    wr16(4, 16'hFFFD); wr(0, 8'h0D);
    step(3); rd16(4, c); chk("R6 wrap to zero", c, 16'h0000);
    chk("R6 ovf flag", ovf, 1'b1); chk("R9 irq ovf", irq, 1'b1);
    trig_pin = 1'b1; step(1); trig_pin = 1'b0; step(1);
    rd16(2, c); chk("R6 captured", c, 16'h0001);
    rd16(4, c); chk("R6 count runs", c, 16'h0002);
    chk("R6 ext flag", ext, 1'b1);
    wr(0, 8'h8D); chk("R11 clear ext", {ovf, ext}, 2'b10);
    wr(0, 8'h0D); chk("R11 clear both", {ovf, ext, irq}, 3'b000);

    // R7 auto-reload up
    wr16(2, 16'h8000); wr16(4, 16'hFFFE); wr(0, 8'h0C);
    step(2); rd16(4, c); chk("R7 reload on wrap", c, 16'h8000);
    chk("R7 ovf", ovf, 1'b1);
    trig_pin = 1'b1; step(1); trig_pin = 1'b0; step(1);
    rd16(4, c); chk("R7 trigger reload", c, 16'h8000);
    chk("R7 ext", ext, 1'b1);
    wr(0, 8'h04); wr16(4, 16'h0100);
    trig_pin = 1'b1; step(1); trig_pin = 1'b0; step(1);
    rd16(4, c); chk("R7 trigger ignored", c, 16'h0102);
    chk("R7 no ext", ext, 1'b0);
    for (int i = 0; i < 4; i++) begin
      r = (i == 0) ? 16'h0000 : (i == 1) ? 16'h1234 : (i == 2) ? 16'hFFF0 : 16'hFFFF;
      wr16(2, r); wr16(4, 16'hFFFF); step(1);
      rd16(4, c); chk("R7 reload sweep", c, r);
    end

    // R8 up/down
    wr(1, 8'h01); wr16(2, 16'h0010); wr16(4, 16'h0013); wr(0, 8'h04);
    m = 16'h0013; ovf_m = 1'b0; ext_m = 1'b0;
    for (int k = 0; k < 8; k++) begin
      step(1);
      if (m == 16'h0010) begin m = 16'hFFFF; ovf_m = 1'b1; ext_m = ~ext_m; end
      else m--;
      rd16(4, c); chk("R8 down step", c, m);
    end
    chk("R8 flags down", {ovf, ext}, {ovf_m, ext_m});
    wr(0, 8'h44);
    chk("R9 ext masked", irq, 1'b0); chk("R9 ext kept", ext, 1'b1);
    trig_pin = 1'b1; wr16(4, 16'hFFFE);
    step(1); rd16(4, c); chk("R8 up", c, 16'hFFFF);
    step(1); rd16(4, c); chk("R8 up wrap", c, 16'h0010);
    chk("R8 up flags", {ovf, ext}, 2'b10);
    step(1); rd16(4, c); chk("R8 up after", c, 16'h0011);
    trig_pin = 1'b0;

    // R10 baud generator
    wr(1, 8'h00); wr(0, 8'h00); wr16(2, 16'hFFFC); wr16(4, 16'hFFFE); wr(0, 8'h25);
    step(1); chk("R10 no pulse", baud, 1'b0);
    step(1); chk("R10 pulse", baud, 1'b1);
    @(negedge clk); chk("R10 one cycle", baud, 1'b0);
    rd16(4, c); chk("R10 reload", c, 16'hFFFC);
    chk("R10 no ovf", ovf, 1'b0);
    wr(0, 8'h14); step(4);
    chk("R10 tx pulse", baud, 1'b1);
    rd16(4, c); chk("R10 tx reload", c, 16'hFFFC);

    // R12 write beats step
    wr(0, 8'h04); wr16(4, 16'h1234);
    wr_tick(4, 8'h55); rd16(4, c); chk("R12 write priority", c, 16'h1255);

    // R11 hardware set beats same-cycle write
    wr(0, 8'h05); wr16(4, 16'hFFFF);
    wr_tick(0, 8'h05); chk("R11 set wins", ovf, 1'b1);
    rd(0, b); chk("R11 ctrl read", b, 8'h85);
    step(3); chk("R11 sticky", ovf, 1'b1);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule